// File: doc/BRIEF.md
# Video Mode Unlock Key Sequencer

This block sits behind a write-only byte register of a video controller and decides which personality the controller runs in: the legacy personality, an enhanced one, or a further extended one. Software unlocks a richer personality by writing two specific byte values back to back. Any write that does not finish such a pair returns the controller to legacy behaviour. The surrounding chip uses the mode code to reshape its memory map.

The sequencer keeps a small armed state recording which pair, if any, the last write opened. Only the next write settles the result. Cycles with no write leave both the armed state and the mode untouched. A one-cycle change pulse goes out whenever the mode value moves, so that the memory-map logic can re-evaluate its decode. The key bytes are parameters. A generate option can leave out the extended personality.

Top module: `vmode_key_seq`

## Requirements
- R1: After reset, `mode` is 0 (legacy), `mode_chg` is 0 and the sequencer is not armed, so a lone write of 0x96 leaves the mode at legacy.
- R2: A write of 0xA5 directly followed by a write of 0x96 sets `mode` to 1 (enhanced).
- R3: A write of 0x47 directly followed by a write of 0x53 sets `mode` to 2 (extended).
- R4: Every write that does not complete one of the two pairs sets `mode` to 0 (legacy). This includes an opening byte, a wrong second byte and a second byte belonging to the other pair.
- R5: Cycles without a write between the opening byte and the closing byte do not disarm the sequencer.
- R6: When the write after an opening byte is itself an opening byte, the sequencer re-arms for the pair that this byte opens.
- R7: `mode_chg` is high for exactly one cycle, in the first cycle that the new `mode` value shows, and only when the value differs from the previous one. Rewriting the same mode gives no pulse.
- R8: Completing a pair disarms the sequencer, so a repeated closing byte then selects legacy.
- R9: Without a write, `mode` holds its value and `mode_chg` stays 0.
- R10: `mode` and `mode_chg` are registered. A write sampled on a rising clock edge is visible on both outputs right after that edge, and code 3 never appears on `mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the key register |
| wr_data | input | DATA_W (8) | Byte written to the key register |
| mode | output | 2 | Personality: 0 legacy, 1 enhanced, 2 extended |
| mode_chg | output | 1 | One-cycle pulse when `mode` changes value |

## Verification
On every cycle, the bound checker enforces the link between the change pulse and a real change of the mode value. It also checks that the mode holds when no write occurs, that the unused code never appears, that a write of a non-closing byte forces legacy, and that entry into the enhanced or extended mode is always preceded by a write of the matching closing byte. Properties of that kind cannot see the armed state. Only the bench's scenarios show that it survives idle gaps, re-arms on a fresh opening byte, clears after a completed pair and ignores a closing byte from the other pair.

// File: rtl/vmode_key_pkg.sv
package vmode_key_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      VM_LEGACY = 2'd0,
      VM_ENH    = 2'd1,
      VM_EXT    = 2'd2
   } vmode_e;

   typedef enum logic [1:0] {
      ARM_NONE = 2'd0,
      ARM_ENH  = 2'd1,
      ARM_EXT  = 2'd2
   } arm_e;

endpackage

// File: rtl/vmode_key_detect.sv
module vmode_key_detect
   import vmode_key_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter bit              EXT_EN  = 1'b1,
   parameter logic [DATA_W-1:0] ENH_K0 = 8'hA5,
   parameter logic [DATA_W-1:0] ENH_K1 = 8'h96,
   parameter logic [DATA_W-1:0] EXT_K0 = 8'h47,
   parameter logic [DATA_W-1:0] EXT_K1 = 8'h53
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hit_enh,
   output logic              hit_ext
);

   arm_e arm_q, arm_d;
   logic open_ext, close_ext;

   // the extended pair exists only when the option is on
   generate
      if (EXT_EN) begin : g_ext
         assign open_ext  = (wr_data == EXT_K0);
         assign close_ext = (arm_q == ARM_EXT) && (wr_data == EXT_K1);
      end else begin : g_no_ext
         assign open_ext  = 1'b0;
         assign close_ext = 1'b0;
      end
   endgenerate

   always_comb begin
      arm_d   = arm_q;
      hit_enh = 1'b0;
      hit_ext = 1'b0;
      if (wr_en) begin
         hit_enh = (arm_q == ARM_ENH) && (wr_data == ENH_K1);
         hit_ext = close_ext;
         if (wr_data == ENH_K0)
            arm_d = ARM_ENH;
         else if (open_ext)
            arm_d = ARM_EXT;
         else
            arm_d = ARM_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         arm_q <= ARM_NONE;
      else
         arm_q <= arm_d;
   end

endmodule

// File: rtl/vmode_mode_reg.sv
module vmode_mode_reg
   import vmode_key_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              hit_enh,
   input  logic              hit_ext,
   output logic [MODE_W-1:0] mode,
   output logic              mode_chg
);

   vmode_e mode_q, mode_d;
   logic   chg_q;

   always_comb begin
      mode_d = mode_q;
      if (wr_en) begin
         if (hit_enh)
            mode_d = VM_ENH;
         else if (hit_ext)
            mode_d = VM_EXT;
         else
            mode_d = VM_LEGACY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= VM_LEGACY;
         chg_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         chg_q  <= (mode_d != mode_q);
      end
   end

   assign mode     = mode_q;
   assign mode_chg = chg_q;

endmodule

// File: rtl/vmode_key_seq.sv
module vmode_key_seq
   import vmode_key_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter bit              EXT_EN  = 1'b1,
   parameter logic [DATA_W-1:0] ENH_K0 = 8'hA5,
   parameter logic [DATA_W-1:0] ENH_K1 = 8'h96,
   parameter logic [DATA_W-1:0] EXT_K0 = 8'h47,
   parameter logic [DATA_W-1:0] EXT_K1 = 8'h53
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [1:0]        mode,
   output logic              mode_chg
);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("vmode_key_seq: DATA_W must be at least 1");
      end
      if (ENH_K0 == ENH_K1) begin : g_bad_enh
         $error("vmode_key_seq: enhanced opening and closing bytes must differ");
      end
      if (EXT_EN && (EXT_K0 == EXT_K1 || EXT_K0 == ENH_K0 || EXT_K0 == ENH_K1 ||
                     EXT_K1 == ENH_K0)) begin : g_bad_ext
         $error("vmode_key_seq: extended key bytes clash with other key bytes");
      end
   endgenerate

   logic hit_enh, hit_ext;

   vmode_key_detect #(
      .DATA_W (DATA_W),
      .EXT_EN (EXT_EN),
      .ENH_K0 (ENH_K0),
      .ENH_K1 (ENH_K1),
      .EXT_K0 (EXT_K0),
      .EXT_K1 (EXT_K1)
   ) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .hit_enh (hit_enh),
      .hit_ext (hit_ext)
   );

   vmode_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .hit_enh  (hit_enh),
      .hit_ext  (hit_ext),
      .mode     (mode),
      .mode_chg (mode_chg)
   );

endmodule

// File: rtl/vmode_key_chk.sv
module vmode_key_chk #(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] ENH_K1 = 8'h96,
   parameter logic [DATA_W-1:0] EXT_K1 = 8'h53
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [1:0]        mode,
   input logic              mode_chg
);

   // R7
   pulse_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> (mode != $past(mode)));

   // R7
   change_gives_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> mode_chg);

   // R9
   idle_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(mode) && !mode_chg));

   // R10
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

   // R4
   non_closing_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != ENH_K1 && wr_data != EXT_K1) |=> (mode == 2'd0));

   // R2
   enh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && $past(mode) != 2'd1) |-> $past(wr_en && wr_data == ENH_K1));

   // R3
   ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(wr_en && wr_data == EXT_K1));

endmodule

bind vmode_key_seq vmode_key_chk #(
   .DATA_W (DATA_W),
   .ENH_K1 (ENH_K1),
   .EXT_K1 (EXT_K1)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .mode     (mode),
   .mode_chg (mode_chg)
);

// File: tb/vmode_key_seq_bench.sv
`timescale 1ns/1ps
module vmode_key_seq_bench;

   typedef struct {
      logic [1:0] mode;
      logic       chg;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] mode;
   logic       mode_chg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t sb_q[$];

   // reference model state
   logic [1:0] m_mode = 2'd0;
   int         m_arm  = 0;

   always #2.5 clk = ~clk;

   vmode_key_seq u_vmode_key_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .mode     (mode),
      .mode_chg (mode_chg)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and pushes the expected outputs
   task automatic drive(input bit w, input logic [7:0] d, input string tag);
      exp_t e;
      logic [1:0] prev;
      @(negedge clk);
      wr_en   = w;
      wr_data = d;
      prev = m_mode;
      if (w) begin
         if (m_arm == 1 && d == 8'h96)      m_mode = 2'd1;
         else if (m_arm == 2 && d == 8'h53) m_mode = 2'd2;
         else                               m_mode = 2'd0;
         m_arm = (d == 8'hA5) ? 1 : (d == 8'h47) ? 2 : 0;
      end
      e.mode = m_mode;
      e.chg  = (m_mode != prev);
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compares right after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.tag, "mode", int'(mode), int'(e.mode));
         check(e.tag, "mode_chg", int'(mode_chg), int'(e.chg));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "reset mode", int'(mode), 0);
      check("R1", "reset mode_chg", int'(mode_chg), 0);
      rst_n = 1'b1;
      drive(0, 8'h00, "R1");
      drive(1, 8'h96, "R1");          // not armed after reset
      drive(1, 8'hA5, "R2");
      drive(1, 8'h96, "R2");          // enhanced, pulse
      drive(0, 8'h00, "R9");
      drive(0, 8'h96, "R9");          // data without strobe is ignored
      drive(1, 8'h96, "R8");          // disarmed after completion
      drive(1, 8'h47, "R3");
      drive(1, 8'h53, "R3");          // extended
      drive(1, 8'h47, "R5");          // drops to legacy, arms
      drive(0, 8'h00, "R5");
      drive(0, 8'h00, "R5");
      drive(1, 8'h53, "R5");          // still armed across idle cycles
      drive(1, 8'hA5, "R6");
      drive(1, 8'h47, "R6");          // re-arm for the other pair
      drive(1, 8'h53, "R6");
      drive(1, 8'hA5, "R4");
      drive(1, 8'h00, "R4");          // wrong closing byte
      drive(1, 8'h96, "R4");          // no longer armed
      drive(1, 8'h47, "R4");
      drive(1, 8'h96, "R4");          // closing byte of the other pair
      drive(1, 8'hA5, "R4");
      drive(1, 8'h53, "R4");
      drive(1, 8'h12, "R7");          // legacy rewritten, no pulse
      drive(1, 8'hA5, "R7");
      drive(1, 8'h96, "R7");
      drive(1, 8'hA5, "R7");          // leaves enhanced, pulse
      drive(1, 8'h96, "R7");          // enters again, pulse
      drive(1, 8'hA5, "R6");
      drive(1, 8'hA5, "R6");          // same opening byte re-arms
      drive(1, 8'h96, "R6");
      drive(0, 8'h00, "R10");
      drive(0, 8'h00, "R10");
      repeat (3) @(negedge clk);
      check("R10", "queue drained", sb_q.size(), 0);
      finish_run();
   end

endmodule